// File: doc/BRIEF.md
# Duplicate Packet Key Validator

This block sits in a network interface. It ties each outgoing message to a short key so that a header flit can be caught before injection if it has been copied or readdressed inside the interface. The processor side presents a sequence count with each new message. The block answers with the lowest free data buffer and the lowest free validation-table slot. It stores the count in that slot and marks both as busy. The processor side computes the key as count XOR buffer id XOR destination. That key is written into a key slot of the reserved buffer, and the key and table index travel in the packet header.

When a header flit leaves the output queue, its destination, key and table index are presented on the check port. The block reads the stored count and recovers a buffer id by XOR-ing key, count and destination. It then looks for the header key among the written key slots of that buffer. One cycle later it reports whether the header is genuine. A changed destination steers the lookup to the wrong buffer, or to no buffer at all, so the header is rejected. A multicast packet carries one key per destination, held in separate key slots. Once the packet has gone, a release frees its buffer and its table slot.

Top module: `key_validator`

## Requirements
- R1: After reset every buffer and every table slot is free, `alloc_gnt` is 1 with `alloc_bid` = 0 and `alloc_cid` = 0, and `chk_done` and `chk_ok` are 0.
- R2: While at least one buffer and one table slot are free, `alloc_gnt` is 1, `alloc_bid` is the lowest-numbered free buffer and `alloc_cid` is the lowest-numbered free table slot. A clock edge with `alloc_req` and `alloc_gnt` both high marks both as busy, stores `alloc_count` in the slot and clears every key slot of the buffer.
- R3: With no free buffer or no free table slot, `alloc_gnt` is 0 and `alloc_req` changes nothing.
- R4: `key_we` writes `key_val` into key slot `key_slot` of buffer `key_bid` when that buffer is busy.
- R5: The recovered buffer id is the 12-bit value `chk_key` XOR stored count[`chk_cid`] XOR `chk_dest` zero-extended from 6 bits.
- R6: A header is valid only when all of these hold: table slot `chk_cid` is busy, the recovered id is below the buffer count (16), that buffer is busy, and one of its written key slots equals `chk_key`. Otherwise it is invalid.
- R7: Each buffer has 2 key slots. A header that matches either written slot is valid, so each destination of a multicast packet is checked on its own.
- R8: `chk_done` is 1 exactly in the cycle after a cycle with `chk_req` high. `chk_ok` is the verdict for that request and is 0 whenever `chk_done` is 0.
- R9: `rel_req` frees buffer `rel_bid` and table slot `rel_cid`. Later headers that rely on them are invalid, and the freed ids are offered again by allocation.
- R10: A check is judged on the state before the clock edge that ends its request cycle. A release in that same cycle still leaves the check valid. An allocation in that same cycle of the slot being checked still leaves the check invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | New outgoing message wants a buffer |
| alloc_count | input | 12 | Sequence count of that message |
| alloc_gnt | output | 1 | A buffer and a table slot are free |
| alloc_bid | output | 4 | Buffer id offered |
| alloc_cid | output | 4 | Table slot offered |
| key_we | input | 1 | Write a key into a buffer |
| key_bid | input | 4 | Buffer receiving the key |
| key_slot | input | 1 | Key slot within the buffer |
| key_val | input | 12 | Key value |
| chk_req | input | 1 | Header flit presented for checking |
| chk_dest | input | 6 | Header destination |
| chk_key | input | 12 | Header key |
| chk_cid | input | 4 | Header table slot |
| chk_done | output | 1 | Verdict available |
| chk_ok | output | 1 | Header valid |
| rel_req | input | 1 | Packet sent, free its resources |
| rel_bid | input | 4 | Buffer to free |
| rel_cid | input | 4 | Table slot to free |

## Verification
A header check can meet a release or an allocation on the same clock edge, and both touch the entries the check reads. The bench triggers both cases. It releases a buffer and its slot in the same cycle as a matching header, and expects a valid verdict followed by an invalid one on the repeat. It also allocates a slot in the same cycle as a check that names it, and expects an invalid verdict. All expected values come from the bench's own record of which entries were busy before the edge.

// File: rtl/key_validator.sv
module key_validator #(
  parameter int NBUF = 16,
  parameter int NTAB = 16,
  parameter int CW   = 12,
  parameter int DW   = 6,
  parameter int MC   = 2,
  localparam int BW  = $clog2(NBUF),
  localparam int TW  = $clog2(NTAB),
  localparam int SW  = (MC > 1) ? $clog2(MC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic [CW-1:0] alloc_count,
  output logic          alloc_gnt,
  output logic [BW-1:0] alloc_bid,
  output logic [TW-1:0] alloc_cid,
  input  logic          key_we,
  input  logic [BW-1:0] key_bid,
  input  logic [SW-1:0] key_slot,
  input  logic [CW-1:0] key_val,
  input  logic          chk_req,
  input  logic [DW-1:0] chk_dest,
  input  logic [CW-1:0] chk_key,
  input  logic [TW-1:0] chk_cid,
  output logic          chk_done,
  output logic          chk_ok,
  input  logic          rel_req,
  input  logic [BW-1:0] rel_bid,
  input  logic [TW-1:0] rel_cid
);
  localparam logic [CW-1:0] NB_C = CW'(NBUF);

  logic [NBUF-1:0] buf_v;
  logic [NTAB-1:0] tab_v;
  logic [CW-1:0]   tab_c [NTAB];
  logic [CW-1:0]   key_m [NBUF][MC];
  logic [MC-1:0]   key_v [NBUF];

  logic bfree, tfree, take, key_go, hit, ok_n;
  logic [CW-1:0] rec;
  logic [BW-1:0] rb;

  always_comb begin
    bfree = 1'b0;
    alloc_bid = '0;
    for (int i = NBUF - 1; i >= 0; i--)
      if (!buf_v[i]) begin
        bfree = 1'b1;
        alloc_bid = BW'(i);
      end
  end

  always_comb begin
    tfree = 1'b0;
    alloc_cid = '0;
    for (int i = NTAB - 1; i >= 0; i--)
      if (!tab_v[i]) begin
        tfree = 1'b1;
        alloc_cid = TW'(i);
      end
  end

  assign alloc_gnt = bfree & tfree;
  assign take      = alloc_req & alloc_gnt;
  assign key_go    = key_we & buf_v[key_bid];

  assign rec = chk_key ^ tab_c[chk_cid] ^ {{(CW-DW){1'b0}}, chk_dest};
  assign rb  = rec[BW-1:0];

  always_comb begin
    hit = 1'b0;
    for (int s = 0; s < MC; s++)
      if (key_v[rb][s] && key_m[rb][s] == chk_key) hit = 1'b1;
  end

  assign ok_n = tab_v[chk_cid] & (rec < NB_C) & buf_v[rb] & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_v    <= '0;
      tab_v    <= '0;
      chk_done <= 1'b0;
      chk_ok   <= 1'b0;
      for (int i = 0; i < NBUF; i++) key_v[i] <= '0;
    end else begin
      chk_done <= chk_req;
      chk_ok   <= chk_req & ok_n;
      if (key_go) key_v[key_bid][key_slot] <= 1'b1;
      if (take) begin
        buf_v[alloc_bid] <= 1'b1;
        tab_v[alloc_cid] <= 1'b1;
        key_v[alloc_bid] <= '0;
      end
      if (rel_req) begin
        buf_v[rel_bid] <= 1'b0;
        tab_v[rel_cid] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) tab_c[alloc_cid] <= alloc_count;
    if (key_go) key_m[key_bid][key_slot] <= key_val;
  end
endmodule

// File: rtl/key_validator_chk.sv
module key_validator_chk #(
  parameter int NBUF = 16,
  parameter int NTAB = 16,
  localparam int BW  = $clog2(NBUF),
  localparam int TW  = $clog2(NTAB)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alloc_req,
  input logic            alloc_gnt,
  input logic [BW-1:0]   alloc_bid,
  input logic            chk_req,
  input logic [TW-1:0]   chk_cid,
  input logic            chk_done,
  input logic            chk_ok,
  input logic            rel_req,
  input logic [BW-1:0]   rel_bid,
  input logic [NBUF-1:0] buf_v,
  input logic [NTAB-1:0] tab_v
);
  assert_done_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> chk_done);
  assert_no_done_without_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_req |=> !chk_done);
  assert_ok_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok |-> chk_done);
  assert_no_grant_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_gnt |-> (&buf_v || &tab_v));
  assert_grant_marks_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_gnt && !(rel_req && rel_bid == alloc_bid)) |=> buf_v[$past(alloc_bid)]);
  assert_empty_entry_rejects_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && !tab_v[chk_cid]) |=> !chk_ok);
endmodule

bind key_validator key_validator_chk #(.NBUF(NBUF), .NTAB(NTAB)) u_key_validator_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
  .alloc_bid(alloc_bid), .chk_req(chk_req), .chk_cid(chk_cid), .chk_done(chk_done),
  .chk_ok(chk_ok), .rel_req(rel_req), .rel_bid(rel_bid), .buf_v(buf_v), .tab_v(tab_v)
);

// File: tb/test_key_validator.sv
module test_key_validator;
  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_req = 0; logic [11:0] alloc_count = 0;
  logic alloc_gnt; logic [3:0] alloc_bid, alloc_cid;
  logic key_we = 0; logic [3:0] key_bid = 0; logic [0:0] key_slot = 0; logic [11:0] key_val = 0;
  logic chk_req = 0; logic [5:0] chk_dest = 0; logic [11:0] chk_key = 0; logic [3:0] chk_cid = 0;
  logic chk_done, chk_ok;
  logic rel_req = 0; logic [3:0] rel_bid = 0, rel_cid = 0;

  int tests = 0, fails = 0;
  bit m_bv[16], m_tv[16], m_kv[16][2];
  logic [11:0] m_tc[16], m_k[16][2];
  logic [5:0] m_d[16];

  always #5 clk = ~clk;

  key_validator i_key_validator (.*);

  task automatic chk(string tag, bit good, int act, int exp);
    tests++;
    if (!good) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_ok(logic [5:0] d, logic [11:0] k, logic [3:0] c);
    int r;
    if (!m_tv[c]) return 0;
    r = int'(k ^ m_tc[c] ^ {6'b0, d});
    if (r >= 16) return 0;
    if (!m_bv[r]) return 0;
    for (int s = 0; s < 2; s++) if (m_kv[r][s] && m_k[r][s] == k) return 1;
    return 0;
  endfunction

  task automatic tick(string tag);
    bit eg = 0, eo = 0, creq;
    int eb = 0, ec = 0;
    for (int i = 15; i >= 0; i--) if (!m_bv[i]) eb = i;
    for (int i = 15; i >= 0; i--) if (!m_tv[i]) ec = i;
    for (int i = 0; i < 16; i++) if (!m_bv[i]) eg = 1;
    begin bit t = 0; for (int i = 0; i < 16; i++) if (!m_tv[i]) t = 1; eg = eg & t; end
    chk("R2/R3 alloc_gnt", alloc_gnt == eg, alloc_gnt, eg);
    if (eg) begin
      chk("R2 alloc_bid", alloc_bid == 4'(eb), alloc_bid, eb);
      chk("R2 alloc_cid", alloc_cid == 4'(ec), alloc_cid, ec);
    end
    creq = chk_req;
    if (chk_req) eo = exp_ok(chk_dest, chk_key, chk_cid);
    @(posedge clk);
    if (key_we && m_bv[key_bid]) begin
      m_kv[key_bid][key_slot] = 1; m_k[key_bid][key_slot] = key_val;
    end
    if (alloc_req && eg) begin
      m_bv[eb] = 1; m_tv[ec] = 1; m_tc[ec] = alloc_count; m_kv[eb][0] = 0; m_kv[eb][1] = 0;
    end
    if (rel_req) begin m_bv[rel_bid] = 0; m_tv[rel_cid] = 0; end
    @(negedge clk);
    chk({"R8 chk_done ", tag}, chk_done == creq, chk_done, creq);
    chk({"R6 chk_ok ", tag}, chk_ok == eo, chk_ok, eo);
    alloc_req = 0; key_we = 0; chk_req = 0; rel_req = 0;
  endtask

  task automatic do_check(string tag, logic [5:0] d, logic [11:0] k, logic [3:0] c);
    chk_req = 1; chk_dest = d; chk_key = k; chk_cid = c;
    tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 gnt", alloc_gnt == 1, alloc_gnt, 1);
    chk("R1 bid", alloc_bid == 0, alloc_bid, 0);
    chk("R1 cid", alloc_cid == 0, alloc_cid, 0);
    chk("R1 done", chk_done == 0 && chk_ok == 0, chk_done, 0);

    // R2 R4: fill all buffers, then write keys
    for (int i = 0; i < 16; i++) begin
      alloc_req = 1; alloc_count = 12'(12'h1A5 + i * 293);
      tick("fill R2");
      m_d[i] = 6'((i * 5 + 1) % 64);
      key_we = 1; key_bid = 4'(i); key_slot = 0;
      key_val = m_tc[i] ^ 12'(i) ^ {6'b0, m_d[i]};
      tick("key R4");
    end
    // R3: full, request ignored
    alloc_req = 1; alloc_count = 12'h777;
    tick("full R3");

    // R5 R6: every buffer against every destination
    for (int b = 0; b < 16; b++)
      for (int d = 0; d < 64; d++)
        do_check("sweep R5", 6'(d), m_k[b][0], 4'(b));
    // R6: recovered id out of range
    do_check("range R6", 6'd0, m_tc[0] ^ 12'h010, 4'd0);
    do_check("range R6", 6'd3, m_tc[2] ^ 12'h123, 4'd2);

    // R7: second destination on buffer 5
    key_we = 1; key_bid = 4'd5; key_slot = 1; key_val = m_tc[5] ^ 12'd5 ^ 12'd40;
    tick("mc key R7");
    do_check("mc dest2 R7", 6'd40, m_tc[5] ^ 12'd5 ^ 12'd40, 4'd5);
    do_check("mc dest1 R7", m_d[5], m_k[5][0], 4'd5);
    do_check("mc wrong R7", 6'd41, m_tc[5] ^ 12'd5 ^ 12'd40, 4'd5);

    // R9: release then reuse
    rel_req = 1; rel_bid = 4'd3; rel_cid = 4'd3;
    tick("release R9");
    do_check("after release R9", m_d[3], m_k[3][0], 4'd3);

    // R10: release in the same cycle as a matching check
    rel_req = 1; rel_bid = 4'd10; rel_cid = 4'd10;
    chk_req = 1; chk_dest = m_d[10]; chk_key = m_k[10][0]; chk_cid = 4'd10;
    tick("rel+chk R10");
    do_check("repeat R10", m_d[10], m_k[10][0], 4'd10);

    // R10: allocation of slot 3 in the same cycle as a check on it
    alloc_req = 1; alloc_count = 12'h0F0;
    chk_req = 1; chk_dest = 6'd2; chk_key = 12'h0F0 ^ 12'd3 ^ 12'd2; chk_cid = 4'd3;
    tick("alloc+chk R10");
    key_we = 1; key_bid = 4'd3; key_slot = 0; key_val = 12'h0F0 ^ 12'd3 ^ 12'd2;
    tick("rekey R9");
    do_check("reused R9", 6'd2, 12'h0F0 ^ 12'd3 ^ 12'd2, 4'd3);
    // R9: offered next is buffer 10 / slot 10
    alloc_req = 1; alloc_count = 12'h222;
    tick("realloc R9");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule